// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block sits between a simple host register bus and an inner register space that the host cannot address directly. The host sees three 32-bit access registers: a command word, a data-in word and a data-out word. Each inner access takes two steps. For a write, the host loads data-in and then writes a command word with the launch flag and the direction flag set. For a read, the host writes a command word with only the launch flag set, and then collects the result from data-out.

The launch flag doubles as the busy indicator. It reads as 1 while the bridge runs one request/ready transaction on the inner bus, and it clears by itself when that transaction ends. Host software polls the flag for a limited number of attempts. The bridge therefore also ends any transaction that a stalled inner slave never acknowledges, after a fixed number of cycles.

Top module: `indir_bridge`

## Requirements
- R1: After reset the command, data-in and data-out registers read 0, the launch flag reads 0 and `in_req` is low.
- R2: The command word is at host offset 0x0, data-in at 0x4 and data-out at 0x8. The command word reads as bit 31 = launch/busy, bit 8 = direction (1 = inner write), bits 7:0 = inner byte address, and all other bits 0. Any other offset reads 0, and host writes to it change nothing.
- R3: A host write to the command word with bit 31 set, while the bridge is idle, raises `in_req` in the cycle that follows. Bit 31 then reads 1 for as long as `in_req` is high.
- R4: During an inner write, `in_we` is 1, `in_addr` equals command bits 7:0 and `in_wdata` equals data-in.
- R5: During an inner read, `in_we` is 0. Data-out takes `in_rdata` on the cycle in which `in_rdy` is high, and it reads back that value once bit 31 has cleared.
- R6: While `in_req` is high and `in_rdy` is low, `in_addr`, `in_we` and `in_wdata` stay stable.
- R7: Bit 31 and `in_req` clear in the cycle after the one in which `in_rdy` is sampled high, and never before the slave has answered unless R8 applies. With a slave delay of d idle cycles, bit 31 reads 1 in exactly d+1 polls after launch.
- R8: If `in_rdy` never rises, `in_req` and bit 31 drop after exactly TIMEOUT cycles of request, and data-out keeps its previous value.
- R9: While bit 31 is 1, host writes to the command word and to data-in are ignored.
- R10: Data-out holds its value until the next inner read completes; inner writes do not change it.
- R11: A command write with bit 31 clear updates the direction and address fields and starts no inner access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_en | input | 1 | Host access strobe, one access per cycle |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | HOST_AW | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational on `host_addr`) |
| in_req | output | 1 | Inner request, held until ready or timeout |
| in_we | output | 1 | Inner write enable |
| in_addr | output | INNER_AW | Inner byte address |
| in_wdata | output | 32 | Inner write data |
| in_rdata | input | 32 | Inner read data |
| in_rdy | input | 1 | Inner ready, completes the request |

## Verification
The main function is tried with write-then-readback pairs to random addresses, with random data and a random slave delay of 0 to 5 cycles. Every readback is compared with a reference model. The number of busy polls is compared with the delay, which separates a bridge that clears busy early or late from a correct one. A slave that never answers exposes a missing or off-by-one timeout and any damage to data-out. Writes to the command word and data-in during a long transaction, followed by readback of both registers and of the target word, show whether the in-flight access can be corrupted.

// File: rtl/indir_bridge.sv
module indir_bridge #(
  parameter int HOST_AW  = 4,
  parameter int INNER_AW = 8,
  parameter int TIMEOUT  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_en,
  input  logic                host_we,
  input  logic [HOST_AW-1:0]  host_addr,
  input  logic [31:0]         host_wdata,
  output logic [31:0]         host_rdata,
  output logic                in_req,
  output logic                in_we,
  output logic [INNER_AW-1:0] in_addr,
  output logic [31:0]         in_wdata,
  input  logic [31:0]         in_rdata,
  input  logic                in_rdy
);
  localparam int GO_BIT = 31;
  localparam int WE_BIT = INNER_AW;
  localparam int TW     = $clog2(TIMEOUT + 1);

  logic                busy_q, we_q;
  logic [INNER_AW-1:0] addr_q;
  logic [31:0]         din_q, dout_q;
  logic [TW-1:0]       tcnt_q;

  wire sel_ctl = host_addr == HOST_AW'(0);
  wire sel_din = host_addr == HOST_AW'(4);
  wire sel_do  = host_addr == HOST_AW'(8);
  wire wr_ok   = host_en && host_we && !busy_q;
  wire launch  = wr_ok && sel_ctl && host_wdata[GO_BIT];
  wire done    = busy_q && in_rdy;
  wire expire  = busy_q && !in_rdy && (tcnt_q == TW'(TIMEOUT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
      din_q  <= '0;
      dout_q <= '0;
      tcnt_q <= '0;
    end else begin
      if (wr_ok && sel_ctl) begin
        we_q   <= host_wdata[WE_BIT];
        addr_q <= host_wdata[INNER_AW-1:0];
      end
      if (wr_ok && sel_din) din_q <= host_wdata;
      if (launch) begin
        busy_q <= 1'b1;
        tcnt_q <= '0;
      end else if (done || expire) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        tcnt_q <= tcnt_q + 1'b1;
      end
      if (done && !we_q) dout_q <= in_rdata;
    end
  end

  logic [31:0] ctl_word;
  always_comb begin
    ctl_word = '0;
    ctl_word[GO_BIT] = busy_q;
    ctl_word[WE_BIT] = we_q;
    ctl_word[INNER_AW-1:0] = addr_q;
  end

  assign host_rdata = sel_ctl ? ctl_word :
                      sel_din ? din_q :
                      sel_do  ? dout_q : 32'h0;

  assign in_req   = busy_q;
  assign in_we    = we_q;
  assign in_addr  = addr_q;
  assign in_wdata = din_q;
endmodule

// File: rtl/indir_bridge_chk.sv
module indir_bridge_chk #(
  parameter int HOST_AW  = 4,
  parameter int INNER_AW = 8,
  parameter int TIMEOUT  = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                host_en,
  input logic                host_we,
  input logic [HOST_AW-1:0]  host_addr,
  input logic [31:0]         host_rdata,
  input logic                in_req,
  input logic                in_we,
  input logic [INNER_AW-1:0] in_addr,
  input logic [31:0]         in_wdata,
  input logic                in_rdy,
  input logic [31:0]         dout_q
);
  localparam int CW = $clog2(TIMEOUT + 2);
  logic [CW-1:0] req_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_cnt <= '0;
    else if (in_req) req_cnt <= req_cnt + 1'b1;
    else req_cnt <= '0;
  end

  // R6
  req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_req && !in_rdy) |=> (!in_req || ($stable(in_addr) && $stable(in_we) && $stable(in_wdata))));

  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_req && in_rdy) |=> !in_req);

  // R3
  go_reflects_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == HOST_AW'(0)) |-> (host_rdata[31] == in_req));

  // R10
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_req && in_rdy && !in_we) |=> $stable(dout_q));

  // R8
  timeout_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_cnt <= CW'(TIMEOUT));

  // R9
  busy_ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_req && host_en && host_we) |=> $stable(in_addr) && $stable(in_wdata));
endmodule

bind indir_bridge indir_bridge_chk #(
  .HOST_AW(HOST_AW), .INNER_AW(INNER_AW), .TIMEOUT(TIMEOUT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_we(host_we),
  .host_addr(host_addr), .host_rdata(host_rdata), .in_req(in_req),
  .in_we(in_we), .in_addr(in_addr), .in_wdata(in_wdata), .in_rdy(in_rdy),
  .dout_q(dout_q)
);

// File: tb/indir_bridge_tb_top.sv
`timescale 1ns/1ps
module indir_bridge_tb_top;
  localparam int TO = 32;

  logic        clk = 0, rst_n = 0;
  logic        host_en = 0, host_we = 0;
  logic [3:0]  host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic        in_req, in_we, in_rdy = 0;
  logic [7:0]  in_addr;
  logic [31:0] in_wdata, in_rdata = 0;

  int errors = 0, checks = 0, hs_count = 0;
  int slave_delay = 0, slave_cnt = 0;
  bit stall = 0, finished = 0;
  logic [31:0] smem [256];
  logic [31:0] ref_mem [256];

  always #2 clk = ~clk;

  indir_bridge #(.HOST_AW(4), .INNER_AW(8), .TIMEOUT(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .in_req(in_req), .in_we(in_we), .in_addr(in_addr), .in_wdata(in_wdata),
    .in_rdata(in_rdata), .in_rdy(in_rdy));

  always @(negedge clk) begin
    if (in_rdy) begin
      in_rdy <= 0;
      slave_cnt <= 0;
    end else if (in_req && !stall) begin
      if (slave_cnt == slave_delay) begin
        in_rdy <= 1;
        hs_count <= hs_count + 1;
        if (in_we) smem[in_addr] <= in_wdata;
        else in_rdata <= smem[in_addr];
      end else slave_cnt <= slave_cnt + 1;
    end else slave_cnt <= 0;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    host_en = 1; host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_en = 0; host_we = 0; host_addr = 0;
  endtask

  task automatic hread(logic [3:0] a, output logic [31:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic poll(output int n);
    logic [31:0] v;
    n = 0;
    forever begin
      hread(4'h0, v);
      if (!v[31]) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    hread(4'h0, v); check("R1 ctl", v, 0);
    hread(4'h4, v); check("R1 din", v, 0);
    hread(4'h8, v); check("R1 dout", v, 0);
    check("R1 in_req", {31'b0, in_req}, 0);
  endtask

  task automatic t_fields();
    logic [31:0] v;
    hwrite(4'h4, 32'hA5A5_0001);
    hread(4'h4, v); check("R2 din readback", v, 32'hA5A5_0001);
    hwrite(4'h0, 32'h0000_FF3C);
    hread(4'h0, v); check("R2 R11 ctl fields", v, 32'h0000_013C);
    check("R11 no request", {31'b0, in_req}, 0);
    hwrite(4'hC, 32'hFFFF_FFFF);
    hread(4'hC, v); check("R2 unmapped reads 0", v, 0);
    hread(4'h4, v); check("R2 unmapped write no effect", v, 32'hA5A5_0001);
  endtask

  task automatic inner_write(logic [7:0] a, logic [31:0] d, int dly);
    int n, hs0;
    slave_delay = dly;
    hwrite(4'h4, d);
    hs0 = hs_count;
    hwrite(4'h0, 32'h8000_0100 | a);
    check("R3 req raised", {31'b0, in_req}, 1);
    check("R4 in_we", {31'b0, in_we}, 1);
    check("R4 in_addr", {24'b0, in_addr}, {24'b0, a});
    check("R4 in_wdata", in_wdata, d);
    poll(n);
    check("R7 busy polls", n, dly + 1);
    check("R7 handshake before clear", hs_count, hs0 + 1);
    ref_mem[a] = d;
  endtask

  task automatic inner_read(logic [7:0] a, int dly);
    int n;
    logic [31:0] v;
    slave_delay = dly;
    hwrite(4'h0, 32'h8000_0000 | a);
    check("R5 in_we low", {31'b0, in_we}, 0);
    poll(n);
    check("R7 read busy polls", n, dly + 1);
    hread(4'h8, v); check("R5 dout", v, ref_mem[a]);
  endtask

  task automatic t_random();
    for (int i = 0; i < 20; i++) begin
      logic [7:0] a = 8'($urandom);
      inner_write(a, $urandom, int'($urandom % 6));
      inner_read(a, int'($urandom % 6));
    end
  endtask

  task automatic t_dout_hold();
    logic [31:0] v;
    inner_write(8'h11, 32'h1234_5678, 1);
    inner_read(8'h11, 0);
    inner_write(8'h22, 32'hCAFE_F00D, 2);
    hread(4'h8, v); check("R10 dout after inner write", v, 32'h1234_5678);
  endtask

  task automatic t_busy_ignore();
    int n;
    logic [31:0] v;
    slave_delay = 10;
    hwrite(4'h4, 32'h0BAD_0001);
    hwrite(4'h0, 32'h8000_0140);
    hwrite(4'h0, 32'h8000_0055);
    hwrite(4'h4, 32'hDEAD_DEAD);
    hread(4'h0, v); check("R9 ctl while busy", v, 32'h8000_0140);
    hread(4'h4, v); check("R9 din while busy", v, 32'h0BAD_0001);
    poll(n);
    ref_mem[8'h40] = 32'h0BAD_0001;
    hread(4'h0, v); check("R9 ctl after", v, 32'h0000_0140);
    inner_read(8'h40, 0);
  endtask

  task automatic t_timeout();
    int n, hs0;
    logic [31:0] v, d0;
    hread(4'h8, d0);
    hs0 = hs_count;
    stall = 1;
    hwrite(4'h0, 32'h8000_0033);
    poll(n);
    check("R8 timeout cycles", n, TO);
    check("R8 no handshake", hs_count, hs0);
    hread(4'h8, v); check("R8 dout kept", v, d0);
    stall = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      smem[i] = 0; ref_mem[i] = 0;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_fields();
    t_random();
    t_dout_hold();
    t_busy_ignore();
    t_timeout();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule